// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into a stream of column addresses, one per clock. A request carries a starting column, a 3-bit length code and an ordering select. For fixed bursts of 1, 2, 4 or 8 beats, the column bits above the burst-size boundary stay fixed and select an aligned block. Only the low bits move, and they wrap inside that block. They follow either a sequential count or an interleaved (XOR) pattern. A full-page burst steps through the whole column space, wrapping from the top column to zero, and ends only when a terminate input is seen.

A memory controller places the block next to its command sequencer. It pulses `start_i` with the column taken from a read or write command. It then uses `col_o` together with `valid_o` on each beat, and `done_o` tells it that the burst has ended.

The controller is a three-state machine. **IDLE** waits for a request. On a start with a legal configuration it takes the *launch* transition to **BURST**. On a start with an illegal configuration it takes the *reject* transition to **FAULT**. **BURST** emits one beat per cycle and takes the *finish* transition back to IDLE on the beat that raises `done_o`. **FAULT** lasts exactly one cycle, raises `err_o`, and takes the *recover* transition back to IDLE.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `valid_o`, `done_o`, `err_o` and `busy_o` are all low.
- R2: The length code maps as follows: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives a full-page burst. A fixed burst emits exactly its number of beats.
- R3: With `interleave_i`=0 (sequential) and burst length BL, beat i carries low bits (start_low + i) mod BL. All column bits at or above log2(BL) equal those of the starting column.
- R4: With `interleave_i`=1 (interleaved), beat i carries low bits start_low XOR i, and the upper bits are held as in R3.
- R5: When `start_i` is sampled at a clock edge, beat 0 (which is the starting column itself) is on `col_o` with `valid_o` high in the following cycle. The remaining beats follow on consecutive cycles.
- R6: `done_o` is high, together with `valid_o`, only on the final beat. In the cycle after it, `valid_o` is low.
- R7: A full-page burst (code 111, sequential) increments the column by one per beat, wrapping from 2^COL_W-1 to 0. It continues until `term_i` is high during a beat. That beat shows `done_o`, and no beat follows it.
- R8: The reserved codes 100, 101 and 110, and code 111 with `interleave_i`=1, are rejected. `err_o` is high for exactly one cycle, the cycle after start, and `valid_o` stays low.
- R9: `start_i` is ignored while `busy_o` is high (BURST or FAULT). A running burst is not altered and no second burst follows.
- R10: `term_i` has no effect on a fixed-length burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a burst (sampled when idle) |
| col_i | input | COL_W | Starting column |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| term_i | input | 1 | Terminate a full-page burst |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | Beat present on `col_o` |
| done_o | output | 1 | Current beat is the last |
| err_o | output | 1 | Illegal request rejected |
| busy_o | output | 1 | Controller not idle |

## Verification
The embedded properties check several rules on every cycle. They confirm that `done_o` never appears without a beat and that `err_o` never coincides with a beat. They confirm that nothing follows a final beat or a rejection. They also check that the block-select bits stay unchanged inside a fixed burst and that full-page beats step by exactly one. What only the stimulus can show is the exact low-bit order for every start offset, length and ordering. The same holds for the beat count, for the latency from start, for the wrap point of the full-page sweep, and for the fact that ignored inputs (a start while busy, a terminate in a fixed burst) leave the address stream intact.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_FAULT = 2'd2
    } bcg_state_t;

    localparam logic [2:0] LEN_ONE   = 3'b000;
    localparam logic [2:0] LEN_TWO   = 3'b001;
    localparam logic [2:0] LEN_FOUR  = 3'b010;
    localparam logic [2:0] LEN_EIGHT = 3'b011;
    localparam logic [2:0] LEN_PAGE  = 3'b111;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [2:0]       code_i,
    input  logic             interleave_i,
    output logic             legal_o,
    output logic             full_o,
    output logic [COL_W-1:0] mask_o,
    output logic [2:0]       last_idx_o
);

    always_comb begin
        legal_o    = 1'b1;
        full_o     = 1'b0;
        mask_o     = '0;
        last_idx_o = 3'd0;
        unique case (code_i)
            LEN_ONE: begin
                mask_o     = COL_W'(0);
                last_idx_o = 3'd0;
            end
            LEN_TWO: begin
                mask_o     = COL_W'(1);
                last_idx_o = 3'd1;
            end
            LEN_FOUR: begin
                mask_o     = COL_W'(3);
                last_idx_o = 3'd3;
            end
            LEN_EIGHT: begin
                mask_o     = COL_W'(7);
                last_idx_o = 3'd7;
            end
            LEN_PAGE: begin
                // the open-ended sweep is only defined for sequential order
                full_o  = 1'b1;
                mask_o  = '1;
                legal_o = !interleave_i;
            end
            default: legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bcg_beat_addr.sv
module bcg_beat_addr #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic             interleave_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] offset;

    always_comb begin
        if (interleave_i)
            offset = base_i ^ beat_i;
        else
            offset = base_i + beat_i;
    end

    // per bit: moving bits come from the offset, block-select bits from the base
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = mask_i[b] ? offset[b] : base_i[b];
    end

endmodule

// File: rtl/bcg_fsm.sv
module bcg_fsm
    import bcg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       legal_i,
    input  logic       final_i,
    output bcg_state_t state_o,
    output logic       launch_o,
    output logic       valid_o,
    output logic       err_o,
    output logic       busy_o
);

    bcg_state_t state_q, state_d;

    always_comb begin
        state_d  = state_q;
        launch_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i && legal_i) begin
                    state_d  = ST_BURST;
                    launch_o = 1'b1;
                end else if (start_i) begin
                    state_d = ST_FAULT;
                end
            end
            ST_BURST: if (final_i) state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        valid_o = (state_q == ST_BURST);
        err_o   = (state_q == ST_FAULT);
        busy_o  = (state_q != ST_IDLE);
    end

    assign state_o = state_q;

    a_r8_fault_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [2:0]       len_code_i,
    input  logic             interleave_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             done_o,
    output logic             err_o,
    output logic             busy_o
);

    logic             legal, full_d, launch, final_beat, last_fixed;
    logic [COL_W-1:0] mask_d;
    logic [2:0]       last_d;
    bcg_state_t       state;

    logic [COL_W-1:0] base_q, mask_q, beat_q;
    logic [2:0]       last_q;
    logic             full_q, ilv_q;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i       (len_code_i),
        .interleave_i (interleave_i),
        .legal_o      (legal),
        .full_o       (full_d),
        .mask_o       (mask_d),
        .last_idx_o   (last_d)
    );

    bcg_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .legal_i  (legal),
        .final_i  (final_beat),
        .state_o  (state),
        .launch_o (launch),
        .valid_o  (valid_o),
        .err_o    (err_o),
        .busy_o   (busy_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            beat_q <= '0;
            last_q <= '0;
            full_q <= 1'b0;
            ilv_q  <= 1'b0;
        end else if (launch) begin
            base_q <= col_i;
            mask_q <= mask_d;
            beat_q <= '0;
            last_q <= last_d;
            full_q <= full_d;
            ilv_q  <= interleave_i;
        end else if (valid_o) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    bcg_beat_addr #(.COL_W(COL_W)) u_addr (
        .base_i       (base_q),
        .mask_i       (mask_q),
        .beat_i       (beat_q),
        .interleave_i (ilv_q),
        .col_o        (col_o)
    );

    assign last_fixed = !full_q && (beat_q == COL_W'(last_q));
    assign final_beat = valid_o && (last_fixed || (full_q && term_i));
    assign done_o     = final_beat;

    a_r6_done_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> valid_o);
    a_r6_nothing_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !valid_o);
    a_r8_err_without_beat: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !valid_o);
    a_r8_err_then_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (!err_o && !valid_o));
    a_r3_block_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !full_q) |->
        ((col_o & ~mask_q) == ($past(col_o) & ~mask_q)));
    a_r7_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && full_q) |->
        (col_o == COL_W'($past(col_o) + 1'b1)));
    a_r5_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_i && legal) |=> (valid_o && col_o == $past(col_i)));

endmodule

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;

    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] col_i = '0;
    logic [2:0]   len_code_i = '0;
    logic         interleave_i = 1'b0;
    logic         term_i = 1'b0;
    logic [W-1:0] col_o;
    logic         valid_o, done_o, err_o, busy_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    burst_col_gen #(.COL_W(W)) u_burst_col_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
        .len_code_i(len_code_i), .interleave_i(interleave_i), .term_i(term_i),
        .col_o(col_o), .valid_o(valid_o), .done_o(done_o), .err_o(err_o),
        .busy_o(busy_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // fixed burst; optional intruding start and terminate at beat 'poke'
    task automatic run_fixed(input int code, input bit ilv, input int col, input int poke);
        int bl = 1 << code;
        int sl = col & (bl - 1);
        @(negedge clk);
        start_i = 1'b1; col_i = W'(col); len_code_i = 3'(code); interleave_i = ilv;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < bl; i++) begin
            int low = ilv ? (sl ^ i) : ((sl + i) & (bl - 1));
            int exp = (col & ~(bl - 1)) | low;
            if (i > 0) @(negedge clk);
            start_i = 1'b0; term_i = 1'b0;
            if (i == poke) begin
                start_i = 1'b1; col_i = W'(col ^ 5); len_code_i = 3'd3; term_i = 1'b1;
            end
            #1;
            check(ilv ? "R4 beat addr" : "R3 beat addr", int'(col_o), exp);
            check("R5 valid", int'(valid_o), 1);
            check("R6 done", int'(done_o), int'(i == bl - 1));
            if (poke >= 0) check("R10 term ignored", int'(done_o), int'(i == bl - 1));
        end
        @(negedge clk);
        start_i = 1'b0; term_i = 1'b0;
        #1;
        check("R2 beat count", int'(valid_o), 0);
        if (poke >= 0) begin
            @(negedge clk); #1;
            check("R9 no second burst", int'(valid_o), 0);
        end
    endtask

    task automatic run_page(input int col, input int stop);
        @(negedge clk);
        start_i = 1'b1; col_i = W'(col); len_code_i = 3'b111; interleave_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i <= stop; i++) begin
            if (i > 0) @(negedge clk);
            term_i = (i == stop);
            #1;
            check("R7 page addr", int'(col_o), (col + i) % (1 << W));
            check("R7 done", int'(done_o), int'(i == stop));
        end
        @(negedge clk);
        term_i = 1'b0;
        #1;
        check("R7 stops after term", int'(valid_o), 0);
    endtask

    task automatic run_reject(input int code, input bit ilv);
        @(negedge clk);
        start_i = 1'b1; col_i = W'(3); len_code_i = 3'(code); interleave_i = ilv;
        @(negedge clk);
        start_i = 1'b1; len_code_i = 3'd0; interleave_i = 1'b0;  // start during FAULT (R9)
        #1;
        check("R8 err", int'(err_o), 1);
        check("R8 no beat", int'(valid_o), 0);
        @(negedge clk);
        start_i = 1'b0;
        #1;
        check("R8 err one cycle", int'(err_o), 0);
        check("R9 start in fault ignored", int'(valid_o), 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1;
        check("R1 valid", int'(valid_o), 0);
        check("R1 done", int'(done_o), 0);
        check("R1 err", int'(err_o), 0);
        check("R1 busy", int'(busy_o), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int code = 0; code < 4; code++)
            for (int ilv = 0; ilv < 2; ilv++)
                for (int col = 0; col < (1 << W); col++)
                    run_fixed(code, ilv[0], col, -1);
        run_fixed(3, 1'b0, 13, 3);
        run_fixed(2, 1'b1, 22, 1);
        run_page(28, 9);
        run_page(0, 0);
        run_page(31, 33);
        for (int code = 4; code < 7; code++) run_reject(code, 1'b0);
        run_reject(7, 1'b1);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule